// File: doc/BRIEF.md
# Known-Answer Self-Test Gate for a Block Cipher

This block sits between a host data path and an external block cipher core and decides when the cipher may carry traffic. As soon as reset is released it runs two known-answer checks of its own through the cipher's request/response port. The first is an ECB encryption of a fixed plaintext under a fixed 256-bit key. The second is an ECB decryption of the matching ciphertext under the same key. It compares each returned block with a stored answer. Host traffic stays shut off until both answers match.

The controller is a five-state machine. It moves RESET_WAIT → KAT_ENC → KAT_DEC → OPERATIONAL when both checks pass. In KAT_ENC and KAT_DEC a mismatched answer or a missing answer takes it to ERROR. Inside each test state a one-bit flag separates the cycle that issues the request from the cycles spent waiting for the answer. ERROR has no exit: it blocks requests, responses and input acceptance until the next reset. A reset is also the only way to run the checks again. Two read-only registers are always readable, with no permission checks: a status word and a fixed version word.

Top module: `selftest_gate`

## Requirements
- R1: While reset is held and in the first cycle after it is released, the status reads busy=1, pass=0, bist_failure=0, and both host_in_ready and host_out_valid are 0.
- R2: The first test request after reset is an encryption (cph_req_decrypt=0) of KAT_PT under KAT_KEY. The second test request is a decryption (cph_req_decrypt=1) of KAT_CT under KAT_KEY, and it is issued only after the first answer matched.
- R3: When the decryption answer equals KAT_PT, the block enters OPERATIONAL and the status reads pass=1, busy=0, bist_failure=0.
- R4: While the tests run (busy=1), host_in_ready and host_out_valid stay 0, and no host request reaches the cipher port. Exactly two requests appear there.
- R5: A wrong answer to either test moves the block to ERROR, where the status reads bist_failure=1, pass=0, busy=0. A wrong encryption answer means the decryption test is never issued.
- R6: In ERROR, cph_req_valid, host_in_ready and host_out_valid stay 0 whatever the host drives, and ERROR persists until reset.
- R7: A test answer is accepted if it arrives by the TIMEOUT_CYC-th rising edge after the edge that took the request. If no answer has arrived by then, the block moves to ERROR.
- R8: Every reset, whether taken from OPERATIONAL or from ERROR, reruns the whole sequence from RESET_WAIT. The block passes if the cipher now answers correctly and returns to ERROR if it fails again.
- R9: In OPERATIONAL, host_in_ready=1, and a host request is forwarded to the cipher port in the same cycle with its key, data and direction unchanged. The cipher's answer appears on host_out_valid and host_out_data in the cycle it arrives.
- R10: reg_rdata is combinational from reg_addr. Address 0 gives the status word, with busy at bit 0, pass at bit 1 and bist_failure at bit 2. Address 1 gives VERSION. Any other address reads 0. Exactly one status bit is set at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also restarts the self-tests |
| host_in_valid | input | 1 | Host request present |
| host_in_decrypt | input | 1 | Host request direction, 1 = decrypt |
| host_in_key | input | KEY_W | Host key |
| host_in_data | input | BLK_W | Host data block |
| host_in_ready | output | 1 | Host request accepted (OPERATIONAL only) |
| host_out_valid | output | 1 | Cipher answer for the host |
| host_out_data | output | BLK_W | Answer block |
| cph_req_valid | output | 1 | Request to the cipher core |
| cph_req_decrypt | output | 1 | Request direction, 1 = decrypt |
| cph_req_key | output | KEY_W | Request key |
| cph_req_data | output | BLK_W | Request block |
| cph_rsp_valid | input | 1 | Answer from the cipher core |
| cph_rsp_data | input | BLK_W | Answer block |
| reg_addr | input | 2 | Register select |
| reg_rdata | output | 32 | Register read data |

## Verification
Each test request leaves the block one rising edge after it enters a test state. The answer is judged on the edge where it is presented, so status can be read half a cycle after that edge. The bench's cipher stub captures requests on rising edges and drives answers on falling edges after a chosen latency. Each check is made just after a falling edge, once the registered state has settled. Host forwarding in OPERATIONAL is combinational, so a host request driven on one falling edge has its answer checked just after the next falling edge when the stub latency is 0. Answer latencies of TIMEOUT_CYC-1 and TIMEOUT_CYC bracket the timeout boundary.

// File: rtl/stg_pkg.sv
package stg_pkg;
    typedef enum logic [2:0] {
        ST_RESET_WAIT,
        ST_KAT_ENC,
        ST_KAT_DEC,
        ST_OPERATIONAL,
        ST_ERROR
    } stg_state_e;

    typedef struct packed {
        logic bist_failure;
        logic pass;
        logic busy;
    } stg_status_t;

    localparam int unsigned STG_REG_W = 32;
endpackage

// File: rtl/stg_kat_fsm.sv
module stg_kat_fsm
    import stg_pkg::*;
#(
    parameter int unsigned KEY_W       = 256,
    parameter int unsigned BLK_W       = 128,
    parameter int unsigned TIMEOUT_CYC = 8,
    parameter logic [KEY_W-1:0] KAT_KEY = '0,
    parameter logic [BLK_W-1:0] KAT_PT  = '0,
    parameter logic [BLK_W-1:0] KAT_CT  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rsp_valid,
    input  logic [BLK_W-1:0] rsp_data,
    output logic             kat_req_valid,
    output logic             kat_req_decrypt,
    output logic [KEY_W-1:0] kat_req_key,
    output logic [BLK_W-1:0] kat_req_data,
    output stg_status_t      status
);
    localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TW-1:0] TMAX = TW'(TIMEOUT_CYC - 1);

    stg_state_e       st, st_nx;
    logic             sent, sent_nx;
    logic [TW-1:0]    timer, timer_nx;
    logic [BLK_W-1:0] answer;

    assign answer = (st == ST_KAT_DEC) ? KAT_PT : KAT_CT;

    always_comb begin
        st_nx    = st;
        sent_nx  = sent;
        timer_nx = timer;
        unique case (st)
            ST_RESET_WAIT: begin
                st_nx    = ST_KAT_ENC;
                sent_nx  = 1'b0;
                timer_nx = '0;
            end
            ST_KAT_ENC, ST_KAT_DEC: begin
                if (!sent) begin
                    sent_nx  = 1'b1;
                    timer_nx = '0;
                end else if (rsp_valid) begin
                    if (rsp_data == answer) begin
                        st_nx   = (st == ST_KAT_ENC) ? ST_KAT_DEC : ST_OPERATIONAL;
                        sent_nx = 1'b0;
                    end else begin
                        st_nx = ST_ERROR;
                    end
                end else if (timer == TMAX) begin
                    st_nx = ST_ERROR;
                end else begin
                    timer_nx = timer + 1'b1;
                end
            end
            ST_OPERATIONAL, ST_ERROR: begin
            end
            default: st_nx = ST_ERROR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_RESET_WAIT;
            sent  <= 1'b0;
            timer <= '0;
        end else begin
            st    <= st_nx;
            sent  <= sent_nx;
            timer <= timer_nx;
        end
    end

    always_comb begin
        kat_req_valid       = (st == ST_KAT_ENC || st == ST_KAT_DEC) && !sent;
        kat_req_decrypt     = (st == ST_KAT_DEC);
        kat_req_key         = KAT_KEY;
        kat_req_data        = (st == ST_KAT_DEC) ? KAT_CT : KAT_PT;
        status.busy         = (st == ST_RESET_WAIT) || (st == ST_KAT_ENC) || (st == ST_KAT_DEC);
        status.pass         = (st == ST_OPERATIONAL);
        status.bist_failure = (st == ST_ERROR);
    end

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_ERROR |=> st == ST_ERROR);

    // R3
    pass_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status.pass) |-> $past(st) == ST_KAT_DEC);

    // R2
    dec_after_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_KAT_DEC && $past(st) != ST_KAT_DEC) |-> $past(st) == ST_KAT_ENC);

    // R7
    timeout_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status.busy && sent && !rsp_valid && timer == TMAX) |=> status.bist_failure);
endmodule

// File: rtl/stg_traffic_gate.sv
module stg_traffic_gate #(
    parameter int unsigned KEY_W = 256,
    parameter int unsigned BLK_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             pass,
    input  logic             fail,
    input  logic             kat_req_valid,
    input  logic             kat_req_decrypt,
    input  logic [KEY_W-1:0] kat_req_key,
    input  logic [BLK_W-1:0] kat_req_data,
    input  logic             host_in_valid,
    input  logic             host_in_decrypt,
    input  logic [KEY_W-1:0] host_in_key,
    input  logic [BLK_W-1:0] host_in_data,
    output logic             host_in_ready,
    output logic             host_out_valid,
    output logic [BLK_W-1:0] host_out_data,
    output logic             cph_req_valid,
    output logic             cph_req_decrypt,
    output logic [KEY_W-1:0] cph_req_key,
    output logic [BLK_W-1:0] cph_req_data,
    input  logic             cph_rsp_valid,
    input  logic [BLK_W-1:0] cph_rsp_data
);
    always_comb begin
        if (busy) begin
            cph_req_valid   = kat_req_valid;
            cph_req_decrypt = kat_req_decrypt;
            cph_req_key     = kat_req_key;
            cph_req_data    = kat_req_data;
        end else begin
            cph_req_valid   = pass & host_in_valid;
            cph_req_decrypt = host_in_decrypt;
            cph_req_key     = host_in_key;
            cph_req_data    = host_in_data;
        end
        host_in_ready  = pass;
        host_out_valid = pass & cph_rsp_valid;
        host_out_data  = pass ? cph_rsp_data : '0;
    end

    // R6
    err_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (!cph_req_valid && !host_in_ready && !host_out_valid));

    // R4
    test_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!host_in_ready && !host_out_valid));
endmodule

// File: rtl/stg_status_regs.sv
module stg_status_regs
    import stg_pkg::*;
#(
    parameter logic [STG_REG_W-1:0] VERSION = 32'h0001_0004
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  stg_status_t          status,
    input  logic [1:0]           reg_addr,
    output logic [STG_REG_W-1:0] reg_rdata
);
    localparam int unsigned ST_W = $bits(stg_status_t);

    always_comb begin
        unique case (reg_addr)
            2'd0:    reg_rdata = {{(STG_REG_W - ST_W){1'b0}}, status};
            2'd1:    reg_rdata = VERSION;
            default: reg_rdata = '0;
        endcase
    end

    // R10
    status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(status));
endmodule

// File: rtl/selftest_gate.sv
module selftest_gate
    import stg_pkg::*;
#(
    parameter int unsigned KEY_W       = 256,
    parameter int unsigned BLK_W       = 128,
    parameter int unsigned TIMEOUT_CYC = 8,
    parameter logic [KEY_W-1:0] KAT_KEY = {128'h0f0e0d0c0b0a09080706050403020100,
                                           128'h00112233445566778899aabbccddeeff},
    parameter logic [BLK_W-1:0] KAT_PT  = 128'h6bc1bee22e409f96e93d7e117393172a,
    parameter logic [BLK_W-1:0] KAT_CT  = 128'h64debce924279af1f94b7c1ab3af1dd5,
    parameter logic [31:0]      VERSION = 32'h0001_0004
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_in_valid,
    input  logic             host_in_decrypt,
    input  logic [KEY_W-1:0] host_in_key,
    input  logic [BLK_W-1:0] host_in_data,
    output logic             host_in_ready,
    output logic             host_out_valid,
    output logic [BLK_W-1:0] host_out_data,
    output logic             cph_req_valid,
    output logic             cph_req_decrypt,
    output logic [KEY_W-1:0] cph_req_key,
    output logic [BLK_W-1:0] cph_req_data,
    input  logic             cph_rsp_valid,
    input  logic [BLK_W-1:0] cph_rsp_data,
    input  logic [1:0]       reg_addr,
    output logic [31:0]      reg_rdata
);
    stg_status_t      status;
    logic             kat_req_valid;
    logic             kat_req_decrypt;
    logic [KEY_W-1:0] kat_req_key;
    logic [BLK_W-1:0] kat_req_data;

    stg_kat_fsm #(
        .KEY_W(KEY_W), .BLK_W(BLK_W), .TIMEOUT_CYC(TIMEOUT_CYC),
        .KAT_KEY(KAT_KEY), .KAT_PT(KAT_PT), .KAT_CT(KAT_CT)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .rsp_valid(cph_rsp_valid), .rsp_data(cph_rsp_data),
        .kat_req_valid(kat_req_valid), .kat_req_decrypt(kat_req_decrypt),
        .kat_req_key(kat_req_key), .kat_req_data(kat_req_data),
        .status(status)
    );

    stg_traffic_gate #(.KEY_W(KEY_W), .BLK_W(BLK_W)) gate_i (
        .clk(clk), .rst_n(rst_n),
        .busy(status.busy), .pass(status.pass), .fail(status.bist_failure),
        .kat_req_valid(kat_req_valid), .kat_req_decrypt(kat_req_decrypt),
        .kat_req_key(kat_req_key), .kat_req_data(kat_req_data),
        .host_in_valid(host_in_valid), .host_in_decrypt(host_in_decrypt),
        .host_in_key(host_in_key), .host_in_data(host_in_data),
        .host_in_ready(host_in_ready),
        .host_out_valid(host_out_valid), .host_out_data(host_out_data),
        .cph_req_valid(cph_req_valid), .cph_req_decrypt(cph_req_decrypt),
        .cph_req_key(cph_req_key), .cph_req_data(cph_req_data),
        .cph_rsp_valid(cph_rsp_valid), .cph_rsp_data(cph_rsp_data)
    );

    stg_status_regs #(.VERSION(VERSION)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .status(status), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
    );

    // R4
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status.busy |-> !host_in_ready);
endmodule

// File: tb/selftest_gate_tb_top.sv
module selftest_gate_tb_top;
    localparam int unsigned KEY_W = 256;
    localparam int unsigned BLK_W = 128;
    localparam int unsigned TMO   = 8;
    localparam logic [KEY_W-1:0] TB_KEY = {128'ha5a5a5a55a5a5a5a0123456789abcdef,
                                           128'hfedcba9876543210c3c3c3c33c3c3c3c};
    localparam logic [BLK_W-1:0] TB_PT  = 128'h00112233445566778899aabbccddeeff;
    localparam logic [BLK_W-1:0] TB_CT  = TB_PT ^ TB_KEY[127:0] ^ TB_KEY[255:128];
    localparam logic [31:0]      TB_VER = 32'h0003_0201;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_in_valid = 1'b0, host_in_decrypt = 1'b0;
    logic [KEY_W-1:0] host_in_key = '0;
    logic [BLK_W-1:0] host_in_data = '0;
    logic host_in_ready, host_out_valid;
    logic [BLK_W-1:0] host_out_data;
    logic cph_req_valid, cph_req_decrypt;
    logic [KEY_W-1:0] cph_req_key;
    logic [BLK_W-1:0] cph_req_data;
    logic cph_rsp_valid = 1'b0;
    logic [BLK_W-1:0] cph_rsp_data = '0;
    logic [1:0] reg_addr = 2'd0;
    logic [31:0] reg_rdata;

    always #5 clk = ~clk;

    selftest_gate #(
        .KEY_W(KEY_W), .BLK_W(BLK_W), .TIMEOUT_CYC(TMO),
        .KAT_KEY(TB_KEY), .KAT_PT(TB_PT), .KAT_CT(TB_CT), .VERSION(TB_VER)
    ) dut_i (.*);

    function automatic logic [BLK_W-1:0] model(input logic [KEY_W-1:0] k, input logic [BLK_W-1:0] d);
        return d ^ k[127:0] ^ k[255:128];
    endfunction

    // cipher stub
    int lat = 0;
    bit mute = 0, bad_enc = 0, bad_dec = 0;
    bit pend = 0;
    int cnt = 0;
    logic [BLK_W-1:0] resp;
    logic log_dec [0:63];
    logic [KEY_W-1:0] log_key [0:63];
    logic [BLK_W-1:0] log_data [0:63];
    int log_n = 0;

    always @(posedge clk) begin
        if (rst_n && cph_req_valid) begin
            if (log_n < 64) begin
                log_dec[log_n]  = cph_req_decrypt;
                log_key[log_n]  = cph_req_key;
                log_data[log_n] = cph_req_data;
            end
            log_n++;
            pend = 1;
            cnt  = lat;
            resp = model(cph_req_key, cph_req_data) ^
                   (((cph_req_decrypt && bad_dec) || (!cph_req_decrypt && bad_enc)) ? 128'h1 : 128'h0);
        end
    end

    always @(negedge clk) begin
        cph_rsp_valid = 1'b0;
        if (!rst_n) pend = 0;
        else if (pend) begin
            if (cnt == 0) begin
                if (!mute) begin
                    cph_rsp_valid = 1'b1;
                    cph_rsp_data  = resp;
                end
                pend = 0;
            end else cnt--;
        end
    end

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [BLK_W-1:0] act, input logic [BLK_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        host_in_valid = 1'b0;
        repeat (3) @(negedge clk);
        log_n = 0;
        rst_n = 1'b1;
        #1;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk); #1;
            if (reg_rdata[2:1] != 2'b00) break;
        end
    endtask

    initial begin
        int dummy;
        int viol;
        dummy = $urandom(2024);
        // R1: reset state
        do_reset();
        chk("R1 status after reset", reg_rdata, 128'h1);
        chk("R1 host_in_ready", host_in_ready, 0);
        chk("R1 host_out_valid", host_out_valid, 0);
        reg_addr = 2'd1; #1;
        chk("R10 version while busy", reg_rdata, TB_VER);
        reg_addr = 2'd0; #1;

        // R4: host pushes during tests, lat=2
        do_reset();
        lat = 2;
        viol = 0;
        for (int i = 0; i < 200; i++) begin
            host_in_valid = 1'b1;
            host_in_data  = {$urandom, $urandom, $urandom, $urandom};
            #1;
            if (reg_rdata[0] && (host_in_ready || host_out_valid)) viol++;
            if (reg_rdata[2:1] != 2'b00) break;
            @(negedge clk);
        end
        host_in_valid = 1'b0;
        chk("R4 no accept or output while busy", viol, 0);
        chk("R4 only two cipher requests", log_n, 2);
        chk("R2 first is encrypt", log_dec[0], 0);
        chk("R2 first data", log_data[0], TB_PT);
        chk("R2 first key", log_key[0][127:0], TB_KEY[127:0]);
        chk("R2 second is decrypt", log_dec[1], 1);
        chk("R2 second data", log_data[1], TB_CT);
        chk("R3 status pass", reg_rdata, 128'h2);

        // R9: random traffic in OPERATIONAL
        lat = 0;
        for (int t = 0; t < 20; t++) begin
            logic [KEY_W-1:0] k;
            logic [BLK_W-1:0] d;
            k = {8{$urandom}};
            d = {$urandom, $urandom, $urandom, $urandom};
            @(negedge clk);
            host_in_valid = 1'b1; host_in_key = k; host_in_data = d;
            host_in_decrypt = t[0];
            #1;
            chk("R9 ready", host_in_ready, 1);
            chk("R9 forwarded data", cph_req_data, d);
            chk("R9 forwarded dir", cph_req_decrypt, t[0]);
            @(negedge clk);
            host_in_valid = 1'b0;
            #1;
            chk("R9 out valid", host_out_valid, 1);
            chk("R9 out data", host_out_data, model(k, d));
        end
        reg_addr = 2'd2; #1;
        chk("R10 unmapped reads zero", reg_rdata, 0);
        reg_addr = 2'd0; #1;

        // R8: reset from OPERATIONAL reruns
        do_reset();
        chk("R8 busy after reset from operational", reg_rdata, 128'h1);
        wait_done();
        chk("R8 rerun passes", reg_rdata, 128'h2);
        chk("R8 rerun issued both tests", log_n, 2);

        // R5: encrypt mismatch
        bad_enc = 1;
        do_reset();
        wait_done();
        chk("R5 enc mismatch fails", reg_rdata, 128'h4);
        chk("R5 decrypt test not issued", log_n, 1);
        // R6: blocked and sticky
        viol = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            host_in_valid = 1'b1;
            host_in_data  = {$urandom, $urandom, $urandom, $urandom};
            #1;
            if (host_in_ready || host_out_valid || cph_req_valid) viol++;
        end
        host_in_valid = 1'b0;
        chk("R6 error blocks traffic", viol, 0);
        chk("R6 no new cipher requests", log_n, 1);
        reg_addr = 2'd1; #1;
        chk("R10 version in error", reg_rdata, TB_VER);
        reg_addr = 2'd0; #1;
        chk("R6 error sticky", reg_rdata, 128'h4);

        // R8: repeat failure stays in error
        do_reset();
        chk("R8 busy after reset from error", reg_rdata, 128'h1);
        wait_done();
        chk("R8 failing again", reg_rdata, 128'h4);
        bad_enc = 0; bad_dec = 1;
        do_reset();
        wait_done();
        chk("R5 dec mismatch fails", reg_rdata, 128'h4);
        chk("R5 both tests issued", log_n, 2);
        bad_dec = 0;
        do_reset();
        wait_done();
        chk("R8 recovery after good reset", reg_rdata, 128'h2);

        // R7: timeout boundary
        lat = TMO - 1;
        do_reset();
        wait_done();
        chk("R7 latest answer accepted", reg_rdata, 128'h2);
        lat = TMO;
        do_reset();
        wait_done();
        chk("R7 one cycle late fails", reg_rdata, 128'h4);
        chk("R7 late enc stops sequence", log_n, 1);
        lat = 1; mute = 1;
        do_reset();
        wait_done();
        chk("R7 no answer fails", reg_rdata, 128'h4);
        mute = 0;

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule